// File: doc/BRIEF.md
# Packet-Gated Stream FIFO

A single-clock first-in first-out buffer for a valid/ready byte stream. Each stored beat holds a data word, a per-byte keep mask and an end-of-packet marker. Storage is a register array whose depth is a power of two, 16 entries or more. The read side shows the oldest beat in the same cycle that it becomes readable. A beat moves on any cycle in which valid and ready are both high on that side.

A static mode input selects between two read policies. In streaming mode a beat can be read as soon as it is stored. In store-and-forward mode the read side stays idle until at least one whole packet, closed by a beat carrying the end marker, is held in the buffer. That packet then leaves back to back. A buffer that fills in this mode with no end marker inside can never drain. The block flags that condition and refuses further beats.

Occupancy leaves the block as two counts: entries held, and entries the reader may take. Four level flags sit beside the counts: two with fixed margins and two with parameter-set thresholds. The mode input may change only while reset is held.

Top module: `pkt_stream_fifo`

## Requirements
- R1: While reset is low, and in the first cycle after it is released: wr_count and rd_count are 0, out_valid is 0, in_ready is 1, almost_empty and prog_empty are 1, and almost_full, prog_full and stalled are 0.
- R2: Beats leave in the order they were accepted, with data, keep and last unchanged. In streaming mode (store_fwd = 0), out_valid is 1 exactly when wr_count is nonzero, so a beat accepted at one clock edge is readable in the next cycle.
- R3: In store-and-forward mode (store_fwd = 1), out_valid is 1 exactly when the buffer holds at least one beat with last = 1. No beat of a packet is offered before the packet's last beat has been accepted.
- R4: in_ready is 0 exactly when wr_count equals DEPTH, so exactly DEPTH beats can be held.
- R5: wr_count is the number of stored beats. It rises by one on an accepted write without a read, falls by one on a read without a write, and is unchanged when both happen in the same cycle.
- R6: In streaming mode rd_count equals wr_count. In store-and-forward mode rd_count counts the stored beats up to and including the most recently stored beat with last = 1, and is 0 if none is stored.
- R7: almost_full is 1 when wr_count >= DEPTH-1 (one slot or none free). almost_empty is 1 when wr_count <= 1.
- R8: prog_full is 1 when wr_count >= PROG_FULL_THR. prog_empty is 1 when wr_count <= PROG_EMPTY_THR.
- R9: stalled is 1 exactly when store_fwd = 1, wr_count = DEPTH and no beat with last = 1 is stored. While it is 1, in_ready and out_valid are both 0.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data, out_keep and out_last hold their values in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| store_fwd | input | 1 | 1: store-and-forward, 0: streaming; change only in reset |
| in_valid | input | 1 | Write beat offered |
| in_ready | output | 1 | Buffer can take a beat |
| in_data | input | DATA_W | Write data word |
| in_keep | input | DATA_W/8 | Write byte keep mask |
| in_last | input | 1 | Write beat ends a packet |
| out_valid | output | 1 | Read beat offered |
| out_ready | input | 1 | Reader takes the beat |
| out_data | output | DATA_W | Oldest data word |
| out_keep | output | DATA_W/8 | Oldest keep mask |
| out_last | output | 1 | Oldest beat ends a packet |
| wr_count | output | log2(DEPTH)+1 | Beats held |
| rd_count | output | log2(DEPTH)+1 | Beats the reader may take |
| almost_full | output | 1 | At most one free slot |
| almost_empty | output | 1 | At most one beat held |
| prog_full | output | 1 | Occupancy at or above PROG_FULL_THR |
| prog_empty | output | 1 | Occupancy at or below PROG_EMPTY_THR |
| stalled | output | 1 | Full with no packet end stored |

## Verification
The bound checker tests these rules on every cycle:
- the one-step movement of the held count for each combination of write and read,
- the link between a full buffer and in_ready,
- rd_count never exceeding wr_count, and matching it in streaming mode,
- the level of the margin flags,
- the stability of a stalled read side,
- the silence of both handshakes while the deadlock flag is up.

Only the bench scenarios can show beat ordering and payload integrity across wrap-around. The same holds for the rule that no packet leaks out before its end beat arrives, for the exact rd_count after partial packets, and for filling into deadlock from a clean reset. Those scenarios compare each offered beat against a queue of accepted beats and track packet ends in the model.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

    // Handshake outcome of one cycle: bit 1 = write accepted, bit 0 = read taken.
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_e;

endpackage

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned WORD_W = 37,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] slot_q [DEPTH];
    logic [DEPTH-1:0]  slot_we;

    // One-hot write select, one decoder per slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot_dec
        assign slot_we[i] = wr_en && (wr_addr == PTR_W'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) begin
                slot_q[i] <= wr_word;
            end
        end
    end

    // The head is read straight out of the array.
    assign rd_word = slot_q[rd_addr];

endmodule

// File: rtl/pkt_fifo_ctrl.sv
module pkt_fifo_ctrl
    import pkt_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_fwd,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             out_ready,
    input  logic             head_last,
    output logic             in_ready,
    output logic             out_valid,
    output logic             push,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] occ,
    output logic [CNT_W-1:0] occ_next,
    output logic [CNT_W-1:0] open_beats,
    output logic             stalled
);

    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] occ;    // beats held
        logic [CNT_W-1:0] pkts;   // beats with the end marker held
        logic [CNT_W-1:0] open;   // beats behind the newest end marker
    } ctrl_state_t;

    ctrl_state_t st_q, st_d;
    fifo_op_e    op;
    logic        pop;

    always_comb begin
        in_ready  = (st_q.occ != FULL_C);
        out_valid = store_fwd ? (st_q.pkts != '0) : (st_q.occ != '0);
        push      = in_valid && in_ready;
        pop       = out_valid && out_ready;
        op        = fifo_op_e'({push, pop});

        st_d = st_q;

        if (push) begin
            st_d.wr_ptr = st_q.wr_ptr + 1'b1;
        end
        if (pop) begin
            st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        end

        case (op)
            OP_PUSH: st_d.occ = st_q.occ + ONE_C;
            OP_POP:  st_d.occ = st_q.occ - ONE_C;
            default: st_d.occ = st_q.occ;
        endcase

        // Packet ends entering and leaving may cancel out.
        case ({push && in_last, pop && head_last})
            2'b10:   st_d.pkts = st_q.pkts + ONE_C;
            2'b01:   st_d.pkts = st_q.pkts - ONE_C;
            default: st_d.pkts = st_q.pkts;
        endcase

        if (push) begin
            st_d.open = in_last ? '0 : (st_q.open + ONE_C);
        end
        // A streaming read may eat into the unfinished packet.
        if (st_d.open > st_d.occ) begin
            st_d.open = st_d.occ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr     = st_q.wr_ptr;
    assign rd_ptr     = st_q.rd_ptr;
    assign occ        = st_q.occ;
    assign occ_next   = st_d.occ;
    assign open_beats = st_q.open;
    assign stalled    = store_fwd && (st_q.occ == FULL_C) && (st_q.pkts == '0);

endmodule

// File: rtl/pkt_fifo_flags.sv
module pkt_fifo_flags #(
    parameter int unsigned DEPTH          = 16,
    parameter int unsigned PROG_FULL_THR  = 12,
    parameter int unsigned PROG_EMPTY_THR = 3,
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] occ_next,
    output logic             almost_full,
    output logic             almost_empty,
    output logic             prog_full,
    output logic             prog_empty
);

    localparam logic [CNT_W-1:0] AF_C = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] AE_C = CNT_W'(1);
    localparam logic [CNT_W-1:0] PF_C = CNT_W'(PROG_FULL_THR);
    localparam logic [CNT_W-1:0] PE_C = CNT_W'(PROG_EMPTY_THR);

    typedef struct packed {
        logic af;
        logic ae;
        logic pf;
        logic pe;
    } level_t;

    level_t lvl_q, lvl_d;

    // Flags are registered from the next occupancy so they line up with it.
    always_comb begin
        lvl_d.af = (occ_next >= AF_C);
        lvl_d.ae = (occ_next <= AE_C);
        lvl_d.pf = (occ_next >= PF_C);
        lvl_d.pe = (occ_next <= PE_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q.af <= 1'b0;
            lvl_q.ae <= 1'b1;
            lvl_q.pf <= (PF_C == '0);
            lvl_q.pe <= 1'b1;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign almost_full  = lvl_q.af;
    assign almost_empty = lvl_q.ae;
    assign prog_full    = lvl_q.pf;
    assign prog_empty   = lvl_q.pe;

endmodule

// File: rtl/pkt_stream_fifo.sv
module pkt_stream_fifo #(
    parameter int unsigned DATA_W         = 32,
    parameter int unsigned DEPTH          = 16,
    parameter int unsigned PROG_FULL_THR  = 12,
    parameter int unsigned PROG_EMPTY_THR = 3,
    localparam int unsigned KEEP_W = DATA_W / 8,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_fwd,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [KEEP_W-1:0] in_keep,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [KEEP_W-1:0] out_keep,
    output logic              out_last,
    output logic [CNT_W-1:0]  wr_count,
    output logic [CNT_W-1:0]  rd_count,
    output logic              almost_full,
    output logic              almost_empty,
    output logic              prog_full,
    output logic              prog_empty,
    output logic              stalled
);

    localparam int unsigned WORD_W = DATA_W + KEEP_W + 1;

    logic              push;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  occ;
    logic [CNT_W-1:0]  occ_next;
    logic [CNT_W-1:0]  open_beats;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] head_word;

    assign wr_word = {in_last, in_keep, in_data};

    pkt_fifo_store #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) store_i (
        .clk     (clk),
        .wr_en   (push),
        .wr_addr (wr_ptr),
        .wr_word (wr_word),
        .rd_addr (rd_ptr),
        .rd_word (head_word)
    );

    pkt_fifo_ctrl #(
        .DEPTH (DEPTH)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_fwd  (store_fwd),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .out_ready  (out_ready),
        .head_last  (head_word[WORD_W-1]),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .push       (push),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .occ        (occ),
        .occ_next   (occ_next),
        .open_beats (open_beats),
        .stalled    (stalled)
    );

    pkt_fifo_flags #(
        .DEPTH          (DEPTH),
        .PROG_FULL_THR  (PROG_FULL_THR),
        .PROG_EMPTY_THR (PROG_EMPTY_THR)
    ) flags_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .occ_next     (occ_next),
        .almost_full  (almost_full),
        .almost_empty (almost_empty),
        .prog_full    (prog_full),
        .prog_empty   (prog_empty)
    );

    assign out_data = head_word[DATA_W-1:0];
    assign out_keep = head_word[DATA_W +: KEEP_W];
    assign out_last = head_word[WORD_W-1];

    assign wr_count = occ;
    assign rd_count = store_fwd ? (occ - open_beats) : occ;

endmodule

// File: rtl/pkt_stream_fifo_chk.sv
module pkt_stream_fifo_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned KEEP_W = DATA_W / 8,
    localparam int unsigned CNT_W  = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              store_fwd,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [KEEP_W-1:0] out_keep,
    input logic              out_last,
    input logic [CNT_W-1:0]  wr_count,
    input logic [CNT_W-1:0]  rd_count,
    input logic              almost_full,
    input logic              almost_empty,
    input logic              stalled
);

    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] AF_C   = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    logic wr_fire, rd_fire;
    assign wr_fire = in_valid && in_ready;
    assign rd_fire = out_valid && out_ready;

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count == FULL_C) |-> !in_ready);                                   // R4
    AST_ROOM_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count < FULL_C) |-> in_ready);                                     // R4
    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !rd_fire) |=> (wr_count == CNT_W'($past(wr_count) + ONE_C))); // R5
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_fire && rd_fire) |=> (wr_count == CNT_W'($past(wr_count) - ONE_C))); // R5
    AST_COUNT_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire == rd_fire) |=> $stable(wr_count));                           // R5
    AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_count <= wr_count);                                                 // R6
    AST_STREAM_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !store_fwd |-> (rd_count == wr_count));                                // R6
    AST_PKT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (store_fwd && out_valid) |-> (rd_count != '0));                        // R3
    AST_AF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        almost_full == (wr_count >= AF_C));                                    // R7
    AST_AE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        almost_empty == (wr_count <= ONE_C));                                  // R7
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> (!in_ready && !out_valid));                                // R9
    AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_keep) && $stable(out_last))); // R10

endmodule

bind pkt_stream_fifo pkt_stream_fifo_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) chk_i (.*);

// File: tb/pkt_stream_fifo_tb_top.sv
`timescale 1ns/1ps
module pkt_stream_fifo_tb_top;

    localparam int DW = 32;
    localparam int KW = DW / 8;
    localparam int DEPTH = 16;
    localparam int PFT = 12;
    localparam int PET = 3;
    localparam int CW = $clog2(DEPTH) + 1;

    typedef struct {
        logic [DW-1:0] d;
        logic [KW-1:0] k;
        logic          l;
    } beat_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic store_fwd = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [KW-1:0] in_keep = '0;
    logic in_last = 1'b0;
    logic out_ready = 1'b0;
    logic in_ready, out_valid, out_last;
    logic [DW-1:0] out_data;
    logic [KW-1:0] out_keep;
    logic [CW-1:0] wr_count, rd_count;
    logic almost_full, almost_empty, prog_full, prog_empty, stalled;

    always #10 clk = ~clk;   // 50 MHz

    pkt_stream_fifo #(
        .DATA_W(DW), .DEPTH(DEPTH), .PROG_FULL_THR(PFT), .PROG_EMPTY_THR(PET)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .store_fwd(store_fwd),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_keep(in_keep), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_keep(out_keep), .out_last(out_last),
        .wr_count(wr_count), .rd_count(rd_count),
        .almost_full(almost_full), .almost_empty(almost_empty),
        .prog_full(prog_full), .prog_empty(prog_empty), .stalled(stalled)
    );

    // Counters: main sequence and monitor keep their own.
    int checks_a = 0, errs_a = 0, checks_b = 0, errs_b = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;
    int rdy_mode = 0;      // 0 never ready, 1 always, 2 pseudo-random
    logic [7:0] lfsr = 8'hA5;

    // Handoff from driver to monitor.
    int    wr_seq = 0;
    beat_t wr_b;

    // Reference model, written only by the monitor.
    beat_t exp_q[$];
    int occ_m = 0, com_m = 0, pkt_m = 0, wr_seen = 0;

    task automatic chk_a(input string tag, input longint act, input longint exp);
        checks_a++;
        if (act != exp) begin
            errs_a++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_b(input string tag, input longint act, input longint exp);
        checks_b++;
        if (act != exp) begin
            errs_b++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (rdy_mode)
            0:       out_ready = 1'b0;
            1:       out_ready = 1'b1;
            default: out_ready = lfsr[0] | lfsr[2];
        endcase
    end

    // Monitor / scoreboard.
    always begin : monitor
        bit rd_go;
        bit rd_l;
        @(negedge clk);
        #2;
        rd_go = 1'b0;
        rd_l  = 1'b0;
        if (!rst_n) begin
            exp_q.delete();
            occ_m = 0; com_m = 0; pkt_m = 0; wr_seen = wr_seq;
        end else begin
            if (chk_en) begin
                chk_b("R5 wr_count", wr_count, occ_m);
                chk_b("R6 rd_count", rd_count, store_fwd ? com_m : occ_m);
                chk_b("R4 in_ready", in_ready, occ_m < DEPTH);
                if (store_fwd) chk_b("R3 out_valid", out_valid, pkt_m > 0);
                else           chk_b("R2 out_valid", out_valid, occ_m > 0);
                chk_b("R7 almost_full", almost_full, occ_m >= DEPTH - 1);
                chk_b("R7 almost_empty", almost_empty, occ_m <= 1);
                chk_b("R8 prog_full", prog_full, occ_m >= PFT);
                chk_b("R8 prog_empty", prog_empty, occ_m <= PET);
                chk_b("R9 stalled", stalled, store_fwd && occ_m == DEPTH && pkt_m == 0);
            end
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk_b("R2 beat offered while model empty", 1, 0);
                end else begin
                    chk_b("R2 out_data", out_data, exp_q[0].d);
                    chk_b("R2 out_keep", out_keep, exp_q[0].k);
                    chk_b("R2 out_last", out_last, exp_q[0].l);
                    if (out_ready) begin
                        rd_go = 1'b1;
                        rd_l  = exp_q[0].l;
                        if (store_fwd) chk_b("R3 read before packet end stored", pkt_m > 0, 1);
                    end
                end
            end
        end
        @(posedge clk);
        #3;
        if (rst_n) begin
            if (rd_go) begin
                void'(exp_q.pop_front());
                occ_m--;
                if (com_m > 0) com_m--;
                if (rd_l) pkt_m--;
            end
            if (wr_seq != wr_seen) begin
                wr_seen = wr_seq;
                exp_q.push_back(wr_b);
                occ_m++;
                if (wr_b.l) begin
                    com_m = occ_m;
                    pkt_m++;
                end
            end
        end
    end

    task automatic send(input logic [DW-1:0] d, input logic [KW-1:0] k, input logic l);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_keep = k; in_last = l;
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        wr_b = '{d, k, l};
        wr_seq++;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic sample();
        @(negedge clk);
        #4;
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        chk_en = 1'b0; rst_n = 1'b0; in_valid = 1'b0; store_fwd = mode;
        repeat (2) @(negedge clk);
        #1;
        chk_a("R1 wr_count in reset", wr_count, 0);
        chk_a("R1 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        #2;
        chk_a("R1 wr_count", wr_count, 0);
        chk_a("R1 rd_count", rd_count, 0);
        chk_a("R1 out_valid", out_valid, 0);
        chk_a("R1 in_ready", in_ready, 1);
        chk_a("R1 almost_empty", almost_empty, 1);
        chk_a("R1 prog_empty", prog_empty, 1);
        chk_a("R1 almost_full", almost_full, 0);
        chk_a("R1 prog_full", prog_full, 0);
        chk_a("R1 stalled", stalled, 0);
        chk_en = 1'b1;
    endtask

    task automatic drain();
        rdy_mode = 1;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            #3;
            if (wr_count == 0) break;
        end
        sample();
        chk_a("R2 all beats delivered", wr_count, 0);
        chk_a("R2 scoreboard empty", exp_q.size(), 0);
    endtask

    initial begin : main
        // A: streaming fill to capacity, then drain.
        do_reset(1'b0);
        rdy_mode = 0;
        for (int i = 0; i < DEPTH; i++) send(32'hA000_0000 + i, 4'hF, (i % 4) == 3);
        sample();
        chk_a("R4 full count", wr_count, DEPTH);
        chk_a("R4 full in_ready", in_ready, 0);
        chk_a("R7 almost_full at full", almost_full, 1);
        chk_a("R8 prog_full at full", prog_full, 1);
        chk_a("R10 head held", out_data, 32'hA000_0000);
        repeat (3) sample();
        chk_a("R10 head still held", out_data, 32'hA000_0000);
        chk_a("R10 valid held", out_valid, 1);
        drain();

        // B: streaming with random read pace and write gaps.
        rdy_mode = 2;
        for (int i = 0; i < 40; i++) begin
            send((i * 32'h0101_0101) ^ 32'h5A5A_0000, (i % 2) ? 4'hF : 4'h3, (i % 5) == 4);
            if (i % 7 == 0) sample();
        end
        drain();

        // C: store-and-forward, a packet held back until its end beat.
        do_reset(1'b1);
        rdy_mode = 1;
        for (int i = 0; i < 3; i++) send(32'hC000_0000 + i, 4'h7, 1'b0);
        sample();
        sample();
        chk_a("R3 no release before end", out_valid, 0);
        chk_a("R6 rd_count partial", rd_count, 0);
        chk_a("R5 wr_count partial", wr_count, 3);
        send(32'hC000_0003, 4'h1, 1'b1);
        sample();
        chk_a("R3 release after end", out_valid, 1);
        chk_a("R6 rd_count whole packet", rd_count, 4);
        drain();

        rdy_mode = 2;
        for (int p = 0; p < 6; p++) begin
            int len = (p % 3 == 0) ? 1 : (p % 3 == 1) ? 5 : 2;
            for (int b = 0; b < len; b++) send(32'hD000_0000 + p * 16 + b, 4'hF, b == len - 1);
        end
        drain();

        // Fill completely with whole packets, then read and write at full.
        rdy_mode = 0;
        for (int i = 0; i < DEPTH; i++) send(32'hE000_0000 + i, 4'hC, (i % 4) == 3);
        sample();
        chk_a("R4 full in store mode", in_ready, 0);
        chk_a("R9 not stalled with packets", stalled, 0);
        rdy_mode = 2;
        for (int i = 0; i < 12; i++) send(32'hF000_0000 + i, 4'hF, (i % 3) == 2);
        drain();

        // D: deadlock when full with no packet end.
        do_reset(1'b1);
        rdy_mode = 1;
        for (int i = 0; i < DEPTH; i++) send(32'hB000_0000 + i, 4'hF, 1'b0);
        sample();
        sample();
        chk_a("R9 stalled", stalled, 1);
        chk_a("R9 in_ready low", in_ready, 0);
        chk_a("R9 out_valid low", out_valid, 0);
        chk_a("R6 rd_count zero", rd_count, 0);

        chk_en = 1'b0;
        done = 1'b1;
        #5;
        $display("Simulation finished: %0d checks, %0d errors",
                 checks_a + checks_b, errs_a + errs_b);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors",
                     checks_a + checks_b + 1, errs_a + errs_b + 1);
            $finish;
        end
    end

endmodule